// File: doc/BRIEF.md
# Sleep Timer Wake Controller

This block sits in the always-on domain and decides when a sleeping device comes back to life. A 32-bit configuration word, loaded through a write strobe, selects which wake sources are armed, which tick clocks the sleep counter, the divisor for the crystal-derived tick, and the sleep duration. After a sleep request the controller enters its sleep state, clears a 28-bit counter and watches three sources: a wake pin, a falling edge on the SPI chip select, and expiry of the sleep counter.

The counter advances either on a ring-oscillator tick or on a low-power tick made by halving the crystal tick and then dividing it by an 11-bit divisor. Expiry compares only counter bits 27:12 against the 16-bit sleep time, so one unit of sleep time is 4096 counter ticks. On a wake the block emits a one-cycle pulse and returns to the awake state.

The state machine has three states: AWAKE (idle, not sleeping), ASLEEP (counter running, sources armed) and WAKE (a single pulse cycle). Transitions: AWAKE to ASLEEP on a sleep request; ASLEEP to WAKE on any armed wake event; WAKE to AWAKE unconditionally on the next cycle. Reset forces AWAKE.

Top module: `swk_ctrl`

## Requirements
- R1: After reset `sleeping_o` and `wake_o` are 0, and the configuration word is 0x0000000E, so the pin, chip-select and counter wake enables (bits 1, 2, 3) are all set.
- R2: A sleep request while awake sets `sleeping_o` on the next cycle; a sleep request while asleep or in the pulse cycle is ignored.
- R3: With bit 1 set, a high level on the wake pin, seen after a two-flop synchronizer, wakes the block.
- R4: With bit 2 set, a falling edge of the synchronized chip select wakes the block.
- R5: With bit 3 set and the counter enable high, the block wakes on the counter tick whose incremented count has bits 27:12 equal to the sleep time in bits 31:16; a sleep time of 0 wakes on the first tick, a sleep time of 1 after exactly 4096 ticks.
- R6: With the counter enable low, the counter does not advance and no expiry wake occurs.
- R7: Bit 4 low selects the ring tick as counter clock; bit 4 high selects the divided low-power tick and ignores the ring tick.
- R8: The low-power tick is the crystal tick halved and then divided by the 11-bit value in bits 15:5; divisor values 0 and 1 both pass the halved tick through.
- R9: A wake source whose enable bit is 0 has no effect; with all three enables clear the block stays asleep until reset.
- R10: A wake is a single-cycle `wake_o` pulse during which `sleeping_o` is already 0, followed by the awake state.
- R11: The counter restarts from zero at every sleep entry, so an interrupted sleep does not shorten the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load strobe for the configuration word |
| cfg_i | input | 32 | Configuration word value |
| sleep_req_i | input | 1 | Request to enter sleep |
| cnt_en_i | input | 1 | Sleep counter enable |
| ring_tick_i | input | 1 | One-cycle tick from the ring oscillator |
| xtal_tick_i | input | 1 | One-cycle tick from the crystal reference |
| wake_pin_i | input | 1 | Asynchronous wake pin, active high |
| spi_cs_ni | input | 1 | Asynchronous SPI chip select, active low |
| sleeping_o | output | 1 | High while in the sleep state |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The assertions watch, on every cycle, the shape of the wake pulse and its exclusion from the sleeping status, the entry into sleep after a request, and that sleep is held when every wake source is disabled or when only the counter could wake but its enable is low. Exact wake timing depends on synchronizer latency, the crystal-halving phase, the divider count and the 4096-tick counter weighting, so only the bench's cycle-by-cycle model and its timed scenarios (sleep times 0 and 1, divisors 0, 1 and 5, an interrupted sleep followed by a full one) can show it.

// File: rtl/swk_pkg.sv
package swk_pkg;

    localparam int CFG_W = 32;
    localparam int TIM_W = 16;
    localparam int DIV_W = 11;
    localparam int CNT_W = 28;

    // Bits 1..3 enable the three wake sources after reset
    localparam logic [CFG_W-1:0] CFG_RST = 32'h0000_000E;

    typedef struct packed {
        logic [TIM_W-1:0] tim;       // 31:16 sleep time, unit = 4096 ticks
        logic [DIV_W-1:0] div;       // 15:5  low-power divisor
        logic             lp_sel;    // 4     counter clock select
        logic             cnt_wake;  // 3     wake on counter expiry
        logic             spi_wake;  // 2     wake on chip-select fall
        logic             pin_wake;  // 1     wake on pin level
        logic             rsvd0;     // 0     unused
    } swk_cfg_t;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WAKE   = 2'd2
    } swk_state_e;

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/swk_tick_gen.sv
module swk_tick_gen #(
    parameter int DIV_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             xtal_tick_i,
    input  logic             ring_tick_i,
    input  logic             lp_sel_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic             half_phase_q;
    logic             half_tick;
    logic [DIV_W-1:0] div_cnt_q;
    logic [DIV_W-1:0] div_last;
    logic             bypass;
    logic             div_wrap;
    logic             lp_tick;

    // Halve the crystal tick: every second crystal tick passes
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_phase_q <= 1'b0;
        end else if (xtal_tick_i) begin
            half_phase_q <= ~half_phase_q;
        end
    end

    assign half_tick = xtal_tick_i & half_phase_q;

    // Divisors 0 and 1 leave the halved tick untouched
    assign bypass   = (div_i[DIV_W-1:1] == '0);
    assign div_last = div_i - DIV_ONE;
    assign div_wrap = bypass | (div_cnt_q >= div_last);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_cnt_q <= '0;
        end else if (half_tick) begin
            div_cnt_q <= div_wrap ? '0 : div_cnt_q + DIV_ONE;
        end
    end

    assign lp_tick = half_tick & div_wrap;
    assign tick_o  = lp_sel_i ? lp_tick : ring_tick_i;

endmodule

// File: rtl/swk_sleep_cnt.sv
module swk_sleep_cnt #(
    parameter int CNT_W = 28,
    parameter int TIM_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [TIM_W-1:0] tim_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CNT_ONE;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_inc;
        end
    end

    // Only the upper field of the count is compared
    assign expire_o = adv_i & (cnt_inc[CNT_W-1 -: TIM_W] == tim_i);

endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl
    import swk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sleep_req_i,
    input  logic             cnt_en_i,
    input  logic             ring_tick_i,
    input  logic             xtal_tick_i,
    input  logic             wake_pin_i,
    input  logic             spi_cs_ni,
    output logic             sleeping_o,
    output logic             wake_o
);

    swk_cfg_t   cfg_q;
    swk_state_e state_q;
    swk_state_e state_d;

    logic pin_s;
    logic cs_s;
    logic cs_d_q;
    logic cs_fall;
    logic cnt_tick;
    logic cnt_clear;
    logic cnt_adv;
    logic cnt_expire;
    logic wake_hit;
    logic unused_rsvd;

    // Configuration word
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= swk_cfg_t'(CFG_RST);
        end else if (cfg_wr_i) begin
            cfg_q <= swk_cfg_t'(cfg_i);
        end
    end

    assign unused_rsvd = cfg_q.rsvd0;

    // Asynchronous inputs into the clock domain
    swk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (wake_pin_i),
        .q_o    (pin_s)
    );

    swk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (spi_cs_ni),
        .q_o    (cs_s)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_d_q <= 1'b1;
        end else begin
            cs_d_q <= cs_s;
        end
    end

    assign cs_fall = cs_d_q & ~cs_s;

    // Counter clock source
    swk_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .xtal_tick_i (xtal_tick_i),
        .ring_tick_i (ring_tick_i),
        .lp_sel_i    (cfg_q.lp_sel),
        .div_i       (cfg_q.div),
        .tick_o      (cnt_tick)
    );

    assign cnt_clear = (state_q == ST_AWAKE) & sleep_req_i;
    assign cnt_adv   = (state_q == ST_ASLEEP) & cnt_en_i & cnt_tick;

    swk_sleep_cnt #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (cnt_clear),
        .adv_i    (cnt_adv),
        .tim_i    (cfg_q.tim),
        .expire_o (cnt_expire)
    );

    assign wake_hit = (cfg_q.pin_wake & pin_s)
                    | (cfg_q.spi_wake & cs_fall)
                    | (cfg_q.cnt_wake & cnt_expire);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:  if (sleep_req_i) state_d = ST_ASLEEP;
            ST_ASLEEP: if (wake_hit)    state_d = ST_WAKE;
            ST_WAKE:                    state_d = ST_AWAKE;
            default:                    state_d = ST_AWAKE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        sleeping_o = 1'b0;
        wake_o     = 1'b0;
        unique case (state_q)
            ST_AWAKE:  ;
            ST_ASLEEP: sleeping_o = 1'b1;
            ST_WAKE:   wake_o     = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/swk_ctrl_chk.sv
module swk_ctrl_chk
    import swk_pkg::*;
(
    input logic     clk_i,
    input logic     rst_ni,
    input logic     cfg_wr_i,
    input logic     sleep_req_i,
    input logic     cnt_en_i,
    input swk_cfg_t cfg_q,
    input logic     sleeping_o,
    input logic     wake_o
);

    a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    a_r10_pulse_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wake_o && sleeping_o));

    a_r10_pulse_from_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(sleeping_o));

    a_r10_return_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !sleeping_o);

    a_r2_enter_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleeping_o && !wake_o && sleep_req_i) |=> sleeping_o);

    a_r9_locked_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleeping_o && !cfg_q.pin_wake && !cfg_q.spi_wake && !cfg_q.cnt_wake && !cfg_wr_i)
        |=> sleeping_o);

    a_r6_counter_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleeping_o && !cnt_en_i && !cfg_q.pin_wake && !cfg_q.spi_wake && !cfg_wr_i)
        |=> sleeping_o);

endmodule

bind swk_ctrl swk_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .sleep_req_i (sleep_req_i),
    .cnt_en_i    (cnt_en_i),
    .cfg_q       (cfg_q),
    .sleeping_o  (sleeping_o),
    .wake_o      (wake_o)
);

// File: tb/swk_ctrl_bench.sv
`timescale 1ns/1ps
module swk_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [31:0] cfg_d;
    logic        sleep_req, cnt_en, ring, xtal, pin, cs_n;
    logic        sleeping, wake;

    always #2.5 clk = ~clk;

    swk_ctrl u_swk_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_i       (cfg_d),
        .sleep_req_i (sleep_req),
        .cnt_en_i    (cnt_en),
        .ring_tick_i (ring),
        .xtal_tick_i (xtal),
        .wake_pin_i  (pin),
        .spi_cs_ni   (cs_n),
        .sleeping_o  (sleeping),
        .wake_o      (wake)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    wakes   = 0;
    int    slp_len = 0;
    int    last_len = 0;
    int    dbl_wake = 0;
    bit    prev_wake = 0;
    string tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 awake, 1 asleep, 2 pulse
    int          m_st;
    bit [1:0]    m_pin, m_cs;
    bit          m_csd, m_ph;
    int          m_dcnt;
    longint      m_cnt;
    bit [31:0]   m_cfg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pin = 2'b00; m_cs = 2'b11; m_csd = 1; m_ph = 0;
            m_dcnt = 0; m_cnt = 0; m_cfg = 32'h0000_000E;
        end else begin
            bit fall, half, lp, tk, exp_hit, hit;
            int dv, nst;
            fall = m_csd && !m_cs[1];
            half = xtal && m_ph;
            dv   = int'(m_cfg[15:5]);
            lp   = half && (dv < 2 || m_dcnt >= dv - 1);
            tk   = m_cfg[4] ? lp : ring;
            exp_hit = (m_st == 1) && cnt_en && tk &&
                      ((((m_cnt + 1) >> 12) & 64'hFFFF) == longint'(m_cfg[31:16]));
            hit  = (m_cfg[1] && m_pin[1]) || (m_cfg[2] && fall) || (m_cfg[3] && exp_hit);
            nst  = m_st;
            if (m_st == 0 && sleep_req) nst = 1;
            else if (m_st == 1 && hit) nst = 2;
            else if (m_st == 2) nst = 0;
            if (m_st == 0 && sleep_req) m_cnt = 0;
            else if (m_st == 1 && cnt_en && tk) m_cnt = (m_cnt + 1) & 64'hFFF_FFFF;
            if (half) m_dcnt = (dv < 2 || m_dcnt >= dv - 1) ? 0 : m_dcnt + 1;
            if (xtal) m_ph = !m_ph;
            m_csd = m_cs[1];
            m_cs  = {m_cs[0], cs_n};
            m_pin = {m_pin[0], pin};
            if (cfg_wr) m_cfg = cfg_d;
            m_st = nst;
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sleeping === (m_st == 1), tag, "sleeping_o (R10 model)", longint'(sleeping), longint'(m_st == 1));
            chk(wake === (m_st == 2), tag, "wake_o (R10 model)", longint'(wake), longint'(m_st == 2));
            if (wake && prev_wake) dbl_wake++;
            prev_wake = wake;
            if (wake) begin
                wakes++;
                last_len = slp_len;
            end
            if (sleeping) slp_len++;
            else slp_len = 0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [31:0] v);
        cfg_d = v; cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_d = '0; sleep_req = 1'b0; cnt_en = 1'b0;
        ring = 1'b0; xtal = 1'b0; pin = 1'b0; cs_n = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(sleeping == 1'b0, "R1", "sleeping_o after reset", longint'(sleeping), 0);
        chk(wake == 1'b0, "R1", "wake_o after reset", longint'(wake), 0);

        // R2/R3: default enables, pin wake
        tag = "R3";
        go_sleep();
        cyc(1);
        chk(sleeping == 1'b1, "R2", "sleeping_o after request", longint'(sleeping), 1);
        sleep_req = 1'b1; cyc(2); sleep_req = 1'b0;
        chk(sleeping == 1'b1, "R2", "request while asleep ignored", longint'(sleeping), 1);
        pin = 1'b1; cyc(6);
        chk(wakes == 1, "R3", "pin wakes with reset enables (R1)", wakes, 1);
        pin = 1'b0; cyc(4);

        // R4: chip-select fall only; pin disabled (R9)
        tag = "R4";
        set_cfg(32'h0000_0004);
        go_sleep(); cyc(2);
        pin = 1'b1; cyc(8);
        chk(sleeping == 1'b1, "R9", "disabled pin ignored", longint'(sleeping), 1);
        cs_n = 1'b0; cyc(6);
        chk(wakes == 2, "R4", "chip-select fall wake", wakes, 2);
        cs_n = 1'b1; pin = 1'b0; cyc(4);

        // R5: sleep time 0 and 1 on ring ticks
        tag = "R5";
        set_cfg(32'h0000_0008);
        cnt_en = 1'b1; ring = 1'b1;
        go_sleep(); cyc(6);
        chk(wakes == 3, "R5", "time 0 wake count", wakes, 3);
        chk(last_len == 1, "R5", "time 0 sleep length", last_len, 1);
        set_cfg(32'h0001_0008);
        go_sleep(); cyc(4100);
        chk(wakes == 4, "R5", "time 1 wake count", wakes, 4);
        chk(last_len == 4096, "R5", "time 1 sleep length", last_len, 4096);

        // R11: interrupted sleep, then a full one
        tag = "R11";
        set_cfg(32'h0001_000A);
        go_sleep(); cyc(1000);
        pin = 1'b1; cyc(6);
        chk(wakes == 5, "R11", "interrupting pin wake", wakes, 5);
        pin = 1'b0; cyc(4);
        go_sleep(); cyc(4100);
        chk(last_len == 4096, "R11", "full length after restart", last_len, 4096);

        // R6: counter enable low holds the counter
        tag = "R6";
        set_cfg(32'h0000_0008);
        cnt_en = 1'b0;
        go_sleep(); cyc(50);
        chk(sleeping == 1'b1, "R6", "no expiry without enable", longint'(sleeping), 1);
        cnt_en = 1'b1; cyc(3);
        chk(wakes == 7, "R6", "expiry once enabled", wakes, 7);

        // R7/R8: low-power tick source
        tag = "R7";
        set_cfg(32'h0000_0018);
        go_sleep(); cyc(40);
        chk(sleeping == 1'b1, "R7", "ring tick ignored on lp source", longint'(sleeping), 1);
        xtal = 1'b1; cyc(5);
        chk(wakes == 8, "R8", "divisor 0 bypass wake", wakes, 8);
        tag = "R8";
        set_cfg(32'h0000_0038);
        go_sleep(); cyc(5);
        chk(wakes == 9, "R8", "divisor 1 bypass wake", wakes, 9);
        chk(last_len <= 2, "R8", "divisor 1 sleep length", last_len, 2);
        set_cfg(32'h0000_00B8);
        go_sleep(); cyc(14);
        chk(wakes == 10, "R8", "divisor 5 wake", wakes, 10);
        chk(last_len >= 1 && last_len <= 10, "R8", "divisor 5 sleep length", last_len, 10);
        set_cfg(32'h0001_0038);
        go_sleep(); cyc(8200);
        chk(last_len >= 8190 && last_len <= 8193, "R8", "divisor 1 time 1 length", last_len, 8192);

        // R9: all sources disabled, only reset recovers
        tag = "R9";
        set_cfg(32'h0000_0000);
        go_sleep();
        pin = 1'b1; cs_n = 1'b0; cyc(100);
        cs_n = 1'b1; cyc(100);
        chk(sleeping == 1'b1, "R9", "locked asleep", longint'(sleeping), 1);
        pin = 1'b0;
        rst_n = 1'b0; cyc(2);
        rst_n = 1'b1; cyc(1);
        chk(sleeping == 1'b0, "R9", "reset recovers", longint'(sleeping), 0);

        chk(dbl_wake == 0, "R10", "wake pulse wider than one cycle", dbl_wake, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule